// File: doc/BRIEF.md
# Sprite Attribute Table DMA Engine

This block fills the 160-byte sprite attribute table, which sits at 0xFE00, with a copy of a block from elsewhere in the address space. Software starts a copy by handing the engine a 16-bit source base address. The engine then uses a byte-read port and a byte-write port on the system bus to move one byte at a time. It moves the first byte in the same clock that accepts the request, and each later byte after four more pulses of a cycle tick input.

For as long as a copy runs, the engine sits between the CPU and the bus. The CPU may still use high RAM (0xFF80 to 0xFFFE). Any other CPU read gets 0xFF and never reaches the bus, and any other CPU write is thrown away. A `busy` output shows when a copy is in flight. If a valid start request arrives during a copy, the engine abandons that copy and starts again from the new base with a full count.

Top module: `oam_dma_engine`

## Requirements
- R1: While `rst` is high and after it is released, `busy`, `src_rd` and `oam_wr` are low until a start request is accepted.
- R2: A start request with `start_base` greater than 0xF100 is discarded: no byte moves and `busy` stays as it was. A base of exactly 0xF100 is accepted.
- R3: An accepted transfer writes exactly 160 bytes to destinations 0xFE00 up to 0xFE9F, beginning at 0xFE00. The engine writes nothing outside that window.
- R4: The first byte moves in the same clock as the accepted request. Each later byte moves in the clock that carries the fourth `tick` pulse counted after the clock of the previous byte.
- R5: Byte k of a transfer is read from `start_base`+k and written to 0xFE00+k. The written data equals the data returned on `src_data` in that clock.
- R6: While `busy` is high, a CPU access to an address below 0xFF80, or to 0xFFFF, is blocked: `cpu_mem_rd` and `cpu_mem_wr` stay low and `cpu_rdata` reads 0xFF.
- R7: While `busy` is high, a CPU access to 0xFF80 through 0xFFFE passes through unchanged in the same clock.
- R8: While `busy` is low, every CPU access passes through unchanged: the enables follow the requests, and `cpu_rdata` equals `cpu_mem_rdata`.
- R9: A valid start request during a transfer restarts the copy from the new base: 0xFE00 is written in that clock, and 160 bytes follow from the new base.
- R10: `busy` is high from the clock that accepts a request through the clock in which the last byte is written, and it is low in the clock after that.
- R11: A rejected start request during a transfer does not disturb it: the remaining bytes keep their addresses and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One pulse per machine cycle; paces the copy |
| start_req | input | 1 | Start request strobe |
| start_base | input | 16 | Source base address for the request |
| src_addr | output | 16 | Read-port address |
| src_rd | output | 1 | Read-port enable (one byte this clock) |
| src_data | input | 8 | Read-port data, valid in the same clock |
| oam_addr | output | 16 | Write-port address |
| oam_wr | output | 1 | Write-port enable |
| oam_data | output | 8 | Write-port data |
| cpu_addr | input | 16 | CPU access address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_mem_rd | output | 1 | CPU read enable forwarded to memory |
| cpu_mem_wr | output | 1 | CPU write enable forwarded to memory |
| cpu_mem_rdata | input | 8 | Read data returned by memory for the CPU |
| cpu_rdata | output | 8 | Read data delivered to the CPU |
| busy | output | 1 | Transfer in progress |

## Verification
The bench goes after the limits of the source range. It uses 0xF100, which must be accepted, and 0xF101 and 0xFFFF, which must be discarded. A comparison that is off by one would either drop a legal copy or start a bogus one. The bench runs one copy with `tick` high only on alternate clocks, so a pacer that counted clocks instead of ticks shows up as bytes arriving on the wrong clock. The bench restarts a copy partway through, and then sends an illegal request during the new copy. A design that mishandled either would finish the old sequence, skip 0xFE00, or lose track of its count. The bench also probes the edges of the CPU window at 0xFF80, 0xFFFE and 0xFFFF, as well as the table itself. A gate with the wrong boundary would let a blocked access through or shut high RAM off.

// File: rtl/oamdma_pkg.sv
package oamdma_pkg;

    typedef logic [15:0] addr_t;
    typedef logic [7:0]  byte_t;

    localparam addr_t DEF_SRC_LIMIT = 16'hF100;
    localparam addr_t DEF_DEST_BASE = 16'hFE00;
    localparam addr_t HRAM_LO       = 16'hFF80;
    localparam addr_t IE_ADDR       = 16'hFFFF;
    localparam byte_t OPEN_BUS      = 8'hFF;

    // One byte move on the bus in the current clock
    typedef struct packed {
        logic  valid;
        addr_t src;
        addr_t dst;
    } move_t;

    function automatic logic base_ok(input addr_t base, input addr_t limit);
        return base <= limit;
    endfunction

    function automatic logic cpu_window(input addr_t a);
        return (a >= HRAM_LO) && (a != IE_ADDR);
    endfunction

endpackage

// File: rtl/oamdma_pacer.sv
module oamdma_pacer #(
    parameter int STRIDE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    input  logic active,
    output logic fire
);
    localparam int PW = (STRIDE > 1) ? $clog2(STRIDE) : 1;
    localparam logic [PW-1:0] LAST = PW'(STRIDE - 1);

    logic [PW-1:0] cnt_q;

    assign fire = active && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart || fire) begin
            cnt_q <= '0;
        end else if (active && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/oamdma_seq.sv
module oamdma_seq
    import oamdma_pkg::*;
#(
    parameter int    NBYTES    = 160,
    parameter addr_t SRC_LIMIT = DEF_SRC_LIMIT,
    parameter addr_t DEST_BASE = DEF_DEST_BASE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_req,
    input  addr_t start_base,
    input  logic  fire,
    output logic  accept,
    output logic  active,
    output move_t mv
);
    localparam int CW = $clog2(NBYTES + 1);
    localparam logic [CW-1:0] FIRST_LEFT = CW'(NBYTES - 1);

    addr_t         src_q;
    logic [CW-1:0] off_q;
    logic [CW-1:0] left_q;
    logic          active_q;
    logic          step;

    assign accept   = start_req && base_ok(start_base, SRC_LIMIT);
    assign step     = active_q && fire && !accept;
    assign active   = active_q;

    always_comb begin
        mv.valid = accept || step;
        mv.src   = accept ? start_base : src_q;
        mv.dst   = DEST_BASE + (accept ? 16'd0 : 16'(off_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q    <= '0;
            off_q    <= '0;
            left_q   <= '0;
            active_q <= 1'b0;
        end else if (accept) begin
            src_q    <= start_base + 16'd1;
            off_q    <= CW'(1);
            left_q   <= FIRST_LEFT;
            active_q <= (NBYTES > 1);
        end else if (step) begin
            src_q    <= src_q + 16'd1;
            off_q    <= off_q + 1'b1;
            left_q   <= left_q - 1'b1;
            active_q <= (left_q != CW'(1));
        end
    end
endmodule

// File: rtl/oamdma_gate.sv
module oamdma_gate
    import oamdma_pkg::*;
(
    input  logic  busy,
    input  addr_t cpu_addr,
    input  logic  cpu_rd,
    input  logic  cpu_wr,
    input  byte_t cpu_mem_rdata,
    output logic  cpu_mem_rd,
    output logic  cpu_mem_wr,
    output byte_t cpu_rdata
);
    logic blocked;

    assign blocked    = busy && !cpu_window(cpu_addr);
    assign cpu_mem_rd = cpu_rd && !blocked;
    assign cpu_mem_wr = cpu_wr && !blocked;
    assign cpu_rdata  = blocked ? OPEN_BUS : cpu_mem_rdata;
endmodule

// File: rtl/oam_dma_engine.sv
module oam_dma_engine
    import oamdma_pkg::*;
#(
    parameter int    NBYTES    = 160,
    parameter int    STRIDE    = 4,
    parameter addr_t SRC_LIMIT = DEF_SRC_LIMIT,
    parameter addr_t DEST_BASE = DEF_DEST_BASE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        start_req,
    input  logic [15:0] start_base,
    output logic [15:0] src_addr,
    output logic        src_rd,
    input  logic [7:0]  src_data,
    output logic [15:0] oam_addr,
    output logic        oam_wr,
    output logic [7:0]  oam_data,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    output logic        cpu_mem_rd,
    output logic        cpu_mem_wr,
    input  logic [7:0]  cpu_mem_rdata,
    output logic [7:0]  cpu_rdata,
    output logic        busy
);
    logic  accept;
    logic  active;
    logic  fire;
    move_t mv;

    oamdma_pacer #(.STRIDE(STRIDE)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (accept),
        .active  (active),
        .fire    (fire)
    );

    oamdma_seq #(
        .NBYTES    (NBYTES),
        .SRC_LIMIT (SRC_LIMIT),
        .DEST_BASE (DEST_BASE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .start_base (start_base),
        .fire       (fire),
        .accept     (accept),
        .active     (active),
        .mv         (mv)
    );

    assign busy     = active || accept;
    assign src_addr = mv.src;
    assign src_rd   = mv.valid;
    assign oam_addr = mv.dst;
    assign oam_wr   = mv.valid;
    assign oam_data = src_data;

    oamdma_gate u_gate (
        .busy          (busy),
        .cpu_addr      (cpu_addr),
        .cpu_rd        (cpu_rd),
        .cpu_wr        (cpu_wr),
        .cpu_mem_rdata (cpu_mem_rdata),
        .cpu_mem_rd    (cpu_mem_rd),
        .cpu_mem_wr    (cpu_mem_wr),
        .cpu_rdata     (cpu_rdata)
    );
endmodule

// File: rtl/oamdma_checker.sv
module oamdma_checker #(
    parameter int          NBYTES    = 160,
    parameter int          STRIDE    = 4,
    parameter logic [15:0] SRC_LIMIT = 16'hF100,
    parameter logic [15:0] DEST_BASE = 16'hFE00
) (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        start_req,
    input logic [15:0] start_base,
    input logic [15:0] src_addr,
    input logic        src_rd,
    input logic [7:0]  src_data,
    input logic [15:0] oam_addr,
    input logic        oam_wr,
    input logic [7:0]  oam_data,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic        cpu_mem_rd,
    input logic        cpu_mem_wr,
    input logic [7:0]  cpu_mem_rdata,
    input logic [7:0]  cpu_rdata,
    input logic        busy
);
    logic        acc_c;
    logic [15:0] last_src_q;
    logic [15:0] last_dst_q;
    logic [15:0] gap_q;
    logic        seen_q;

    assign acc_c = start_req && (start_base <= SRC_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_src_q <= '0;
            last_dst_q <= '0;
            gap_q      <= '0;
            seen_q     <= 1'b0;
        end else if (oam_wr) begin
            last_src_q <= src_addr;
            last_dst_q <= oam_addr;
            gap_q      <= '0;
            seen_q     <= 1'b1;
        end else if (tick && gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) rst |-> !oam_wr || start_req);

    assert_reject_R2: assert property (@(posedge clk) disable iff (rst)
        (start_req && start_base > SRC_LIMIT && !busy) |-> !oam_wr);

    assert_first_dest_R3: assert property (@(posedge clk) disable iff (rst)
        acc_c |-> (oam_wr && oam_addr == DEST_BASE && src_addr == start_base));

    assert_window_R3: assert property (@(posedge clk) disable iff (rst)
        oam_wr |-> (oam_addr >= DEST_BASE && oam_addr < DEST_BASE + 16'(NBYTES)));

    assert_pace_R4: assert property (@(posedge clk) disable iff (rst)
        (oam_wr && !acc_c) |-> (tick && gap_q == 16'(STRIDE - 1)));

    assert_incr_R5: assert property (@(posedge clk) disable iff (rst)
        (oam_wr && !acc_c && seen_q) |->
            (src_addr == last_src_q + 16'd1 && oam_addr == last_dst_q + 16'd1));

    assert_copy_R5: assert property (@(posedge clk) disable iff (rst)
        oam_wr |-> (src_rd && oam_data == src_data));

    assert_block_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && (cpu_addr < 16'hFF80 || cpu_addr == 16'hFFFF)) |->
            (!cpu_mem_rd && !cpu_mem_wr && cpu_rdata == 8'hFF));

    assert_hram_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && cpu_addr >= 16'hFF80 && cpu_addr != 16'hFFFF) |->
            (cpu_mem_rd == cpu_rd && cpu_mem_wr == cpu_wr && cpu_rdata == cpu_mem_rdata));

    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cpu_mem_rd == cpu_rd && cpu_mem_wr == cpu_wr
                   && cpu_rdata == cpu_mem_rdata && !oam_wr));

    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        oam_wr |-> busy);
endmodule

bind oam_dma_engine oamdma_checker #(
    .NBYTES    (NBYTES),
    .STRIDE    (STRIDE),
    .SRC_LIMIT (SRC_LIMIT),
    .DEST_BASE (DEST_BASE)
) u_chk (.*);

// File: tb/sim_oam_dma_engine.sv
module sim_oam_dma_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick;
    logic        start_req = 1'b0;
    logic [15:0] start_base = '0;
    logic [15:0] src_addr;
    logic        src_rd;
    logic [7:0]  src_data;
    logic [15:0] oam_addr;
    logic        oam_wr;
    logic [7:0]  oam_data;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_mem_rd;
    logic        cpu_mem_wr;
    logic [7:0]  cpu_mem_rdata = 8'h3C;
    logic [7:0]  cpu_rdata;
    logic        busy;

    int   cyc = 0;
    int   nchk = 0;
    int   nbad = 0;
    logic tick_mode = 1'b0;

    typedef struct {
        int          at;
        logic [15:0] src;
        logic [15:0] dst;
        logic [7:0]  dat;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign tick     = tick_mode ? cyc[0] : 1'b1;
    assign src_data = pat(src_addr);

    oam_dma_engine u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .start_req(start_req), .start_base(start_base),
        .src_addr(src_addr), .src_rd(src_rd), .src_data(src_data),
        .oam_addr(oam_addr), .oam_wr(oam_wr), .oam_data(oam_data),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_mem_rd(cpu_mem_rd), .cpu_mem_wr(cpu_mem_wr),
        .cpu_mem_rdata(cpu_mem_rdata), .cpu_rdata(cpu_rdata),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit tick_at(input int c);
        return (tick_mode == 1'b0) || (c % 2 != 0);
    endfunction

    // Driver side of the scoreboard: expected byte moves of one transfer
    task automatic push_xfer(input logic [15:0] base, input int c0);
        int c = c0;
        sbq.delete();
        for (int i = 0; i < 160; i++) begin
            exp_t e;
            if (i > 0) begin
                int n = 0;
                while (n < 4) begin
                    c++;
                    if (tick_at(c)) n++;
                end
            end
            e.at  = c;
            e.src = base + 16'(i);
            e.dst = 16'hFE00 + 16'(i);
            e.dat = pat(base + 16'(i));
            sbq.push_back(e);
        end
    endtask

    task automatic start(input logic [15:0] base);
        bit was_busy;
        @(negedge clk);
        was_busy   = (sbq.size() > 0);
        start_req  = 1'b1;
        start_base = base;
        if (base <= 16'hF100) push_xfer(base, cyc);
        #1;
        if (base > 16'hF100 && !was_busy)
            chk(!busy && !oam_wr, "R2", "rejected start moved", {busy, oam_wr}, 0);
        if (base > 16'hF100 && was_busy)
            chk(busy && sbq.size() > 0, "R11", "rejected start disturbed busy", busy, 1);
        if (base <= 16'hF100)
            chk(oam_wr && oam_addr == 16'hFE00, "R9", "start writes 0xFE00", oam_addr, 16'hFE00);
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic wait_done();
        while (sbq.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic probe(input logic [15:0] a, input bit rd, input bit wr,
                         input bit blk, input string req);
        @(negedge clk);
        cpu_addr = a;
        cpu_rd   = rd;
        cpu_wr   = wr;
        #1;
        chk(cpu_mem_rd == (rd && !blk), req, "cpu_mem_rd", cpu_mem_rd, rd && !blk);
        chk(cpu_mem_wr == (wr && !blk), req, "cpu_mem_wr", cpu_mem_wr, wr && !blk);
        if (rd)
            chk(cpu_rdata == (blk ? 8'hFF : 8'h3C), req, "cpu_rdata",
                cpu_rdata, blk ? 8'hFF : 8'h3C);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
    endtask

    // Monitor side of the scoreboard
    initial begin
        exp_t e;
        bit   eb;
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                eb = (sbq.size() > 0);
                chk(busy == eb, "R10", "busy", busy, eb);
                if (oam_wr) begin
                    if (sbq.size() == 0) begin
                        chk(0, "R3", "extra byte at", oam_addr, 0);
                    end else begin
                        e = sbq.pop_front();
                        chk(cyc == e.at, "R4", "byte clock", cyc, e.at);
                        chk(oam_addr == e.dst, "R3", "dest", oam_addr, e.dst);
                        chk(src_addr == e.src, "R5", "source", src_addr, e.src);
                        chk(oam_data == e.dat, "R5", "data", oam_data, e.dat);
                    end
                end else if (sbq.size() > 0 && sbq[0].at <= cyc) begin
                    e = sbq.pop_front();
                    chk(0, "R4", "missing byte for dest", e.dst, e.at);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #2;
        chk(!busy && !oam_wr && !src_rd, "R1", "reset outputs", {busy, oam_wr, src_rd}, 0);
        rst = 1'b0;
        @(negedge clk);
        #2;
        chk(!busy && !oam_wr, "R1", "idle after reset", {busy, oam_wr}, 0);
        probe(16'h1234, 1, 0, 0, "R8");

        // plain copy with CPU probes at the window edges
        start(16'hC000);
        probe(16'h8000, 1, 0, 1, "R6");
        probe(16'hC100, 0, 1, 1, "R6");
        probe(16'hFE10, 1, 0, 1, "R6");
        probe(16'hFFFF, 1, 1, 1, "R6");
        probe(16'hFF7F, 1, 0, 1, "R6");
        probe(16'hFF80, 1, 0, 0, "R7");
        probe(16'hFFFE, 1, 1, 0, "R7");
        wait_done();
        probe(16'h8000, 1, 0, 0, "R8");
        probe(16'hFFFF, 0, 1, 0, "R8");

        // source limit
        start(16'hF101);
        start(16'hFFFF);
        repeat (3) @(negedge clk);
        start(16'hF100);
        wait_done();

        // sparse ticks
        tick_mode = 1'b1;
        start(16'h8000);
        wait_done();
        tick_mode = 1'b0;

        // restart, then an illegal request mid-transfer
        start(16'hC000);
        repeat (50) @(negedge clk);
        start(16'hD000);
        repeat (30) @(negedge clk);
        start(16'hF200);
        wait_done();
        probe(16'hC000, 1, 0, 0, "R8");

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule